// File: doc/BRIEF.md
# Gshare Branch Prediction Unit

This block sits in the fetch stage. For every fetch address it returns a taken/not-taken guess, a next-fetch target and a copy of the global history that was used to form the guess. A table of 2-bit saturating counters gives the direction. The table is indexed by XOR-ing word-aligned PC bits with a 12-bit global history register. A direct-mapped, tagged target buffer supplies targets and the kind of each branch it has seen. A circular return stack supplies the target of returns. When the target buffer does not recognise an address, the prediction is always fall-through.

The execute stage sends resolved branches back through the update port. Conditional branches train the counter at the index formed from their PC and the history snapshot they carried. Taken branches, and all jumps, calls and returns, write the target buffer. Fetch or decode drives the push and pop hints for the return stack. When a resolved branch is flagged as mispredicted, the history is rebuilt from the snapshot the branch carried.

Top module: `gshare_bpu`

## Requirements
- R1: After reset the history is 0, every target-buffer entry is invalid, and every return-stack slot and the stack pointer are 0. Any lookup therefore reports no hit, not-taken and a target of PC+4.
- R2: The counter index is PC[13:2] XOR history[11:0]. A conditional branch that hits in the target buffer is predicted taken, to its stored target, exactly when its counter is 2 or 3. Counters start at 1.
- R3: A resolved conditional branch moves its counter one step towards its outcome. The counter saturates at 3 when taken and at 0 when not taken.
- R4: On a target-buffer miss the lookup predicts not-taken with target PC+4, whatever the counter holds.
- R5: The target buffer is indexed by PC[10:2] (512 entries). It is tagged with PC[30:11]. A write replaces the whole entry, so an alias with a different tag misses.
- R6: A hit on an entry of kind jump (1) or call (2) predicts taken to the stored target. Kind codes are: 0 conditional, 1 jump, 2 call, 3 return.
- R7: A hit on an entry of kind return (3) predicts taken to the current top of the return stack.
- R8: A push advances the pointer circularly and writes the address. A pop moves the pointer back circularly. A simultaneous push and pop overwrites the top in place. Overflow overwrites the oldest slot, and a pop from an empty stack exposes whatever the slot at the pointer holds.
- R9: A valid lookup that hits a conditional entry shifts its predicted direction into history bit 0 on the next edge. The history output shows the value used for the index, before the shift.
- R10: A valid resolved branch flagged mispredicted sets the history to {snapshot[10:0], actual outcome} if it is conditional, or to the snapshot otherwise. This takes priority over the lookup shift in the same cycle.
- R11: A resolved conditional branch that was not taken leaves the target buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup is a real fetch; enables the speculative history shift |
| lk_pc | input | 64 | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction |
| lk_target | output | 64 | Predicted next fetch address |
| lk_btb_hit | output | 1 | Target buffer recognised the address |
| lk_ghr | output | 12 | History used for this lookup (snapshot to carry with the branch) |
| up_valid | input | 1 | A branch has resolved |
| up_pc | input | 64 | Address of the resolved branch |
| up_taken | input | 1 | Actual direction |
| up_target | input | 64 | Actual target |
| up_kind | input | 2 | Branch kind: 0 cond, 1 jump, 2 call, 3 return |
| up_mispredict | input | 1 | Branch was mispredicted; rebuild history |
| up_ghr_snap | input | 12 | History snapshot taken at the branch's lookup |
| ras_push | input | 1 | Call seen: push return address |
| ras_push_addr | input | 64 | Return address to push |
| ras_pop | input | 1 | Return seen: pop the stack |

## Verification
The prediction outputs are combinational from the lookup address and the stored state, so they are due in the same cycle the address is applied. Every update, push, pop and history change becomes visible one clock edge later. The bench drives all inputs just after a falling edge and samples the outputs 1 ns later. Its reference model of counters, buffer, stack and history advances exactly once per rising edge, after the comparison for that cycle. Directed cases apply the lookup with lk_valid low, so the history stays put while counters are stepped to their limits.

// File: rtl/bpu_pkg.sv
// Package: shared types and helpers for the gshare branch prediction unit.
// Assumes word-aligned instructions (PC bits [1:0] carry no information).
package bpu_pkg;

    // Branch kind carried by updates and stored in the target buffer
    typedef enum logic [1:0] {
        BK_COND = 2'd0,
        BK_JUMP = 2'd1,
        BK_CALL = 2'd2,
        BK_RET  = 2'd3
    } br_kind_e;

    // Saturating step of a 2-bit direction counter
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
        if (up) begin
            return (cur == 2'd3) ? 2'd3 : cur + 2'd1;
        end
        return (cur == 2'd0) ? 2'd0 : cur - 2'd1;
    endfunction

endpackage

// File: rtl/bpu_hist_reg.sv
// Module: global history register.
// Shifts in a speculative direction on request. It is rebuilt from a
// snapshot when a misprediction is reported, and the rebuild wins over
// the speculative shift.
module bpu_hist_reg #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              fix_en,
    input  logic              fix_is_cond,
    input  logic              fix_bit,
    input  logic [HIST_W-1:0] fix_snap,
    output logic [HIST_W-1:0] hist
);

    // History update: repair has priority over speculation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (fix_en) begin
            if (fix_is_cond) begin
                hist <= {fix_snap[HIST_W-2:0], fix_bit};
            end else begin
                hist <= fix_snap;
            end
        end else if (spec_en) begin
            hist <= {hist[HIST_W-2:0], spec_bit};
        end
    end

endmodule

// File: rtl/bpu_pht.sv
// Module: direction counter table.
// 2**IDX_W two-bit counters with one combinational read port and one
// write port. All counters reset to 1 (weakly not taken). A read and a
// write to the same index in one cycle return the old value.
module bpu_pht #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import bpu_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] ctr [DEPTH];

    // Read: upper half of the counter range means taken
    assign rd_taken = ctr[rd_idx][1];

    // Training: saturating step towards the resolved outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr[i] <= 2'd1;
            end
        end else if (wr_en) begin
            ctr[wr_idx] <= ctr_step(ctr[wr_idx], wr_taken);
        end
    end

endmodule

// File: rtl/bpu_btb.sv
// Module: direct-mapped tagged target buffer.
// Each entry holds a valid bit, a tag, a target and a branch kind.
// The caller supplies index and tag slices. A write replaces the entry.
// Only the valid bits are reset.
module bpu_btb #(
    parameter int DEPTH  = 512,
    parameter int TAG_W  = 20,
    parameter int ADDR_W = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(DEPTH)-1:0]    rd_idx,
    input  logic [TAG_W-1:0]            rd_tag,
    output logic                        rd_hit,
    output logic [ADDR_W-1:0]           rd_target,
    output bpu_pkg::br_kind_e           rd_kind,
    input  logic                        wr_en,
    input  logic [$clog2(DEPTH)-1:0]    wr_idx,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [ADDR_W-1:0]           wr_target,
    input  bpu_pkg::br_kind_e           wr_kind
);
    import bpu_pkg::*;

    logic [DEPTH-1:0]  vld;
    logic [TAG_W-1:0]  tag_q [DEPTH];
    logic [ADDR_W-1:0] tgt_q [DEPTH];
    br_kind_e          kind_q [DEPTH];

    // Lookup: hit when the entry is valid and its tag matches
    always_comb begin
        rd_hit    = vld[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = tgt_q[rd_idx];
        rd_kind   = kind_q[rd_idx];
    end

    // Valid bits: cleared by reset, set on allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: no reset needed, guarded by the valid bit
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            tgt_q[wr_idx]  <= wr_target;
            kind_q[wr_idx] <= wr_kind;
        end
    end

endmodule

// File: rtl/bpu_ras.sv
// Module: circular return address stack.
// The pointer addresses the top slot. Push pre-increments and pop
// post-decrements, both wrapping at DEPTH, so overflow overwrites the
// oldest slot and underflow exposes stale data. Push and pop together
// replace the top. Any depth of at least two is allowed.
module bpu_ras #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [ADDR_W-1:0]        push_addr,
    input  logic                     pop,
    output logic [ADDR_W-1:0]        top,
    output logic [$clog2(DEPTH)-1:0] ptr
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] stk [DEPTH];
    logic [PTR_W-1:0]  ptr_up;
    logic [PTR_W-1:0]  ptr_dn;

    // Neighbouring pointer values with explicit wrap
    always_comb begin
        ptr_up = (ptr == LAST) ? '0 : ptr + 1'b1;
        ptr_dn = (ptr == '0) ? LAST : ptr - 1'b1;
    end

    assign top = stk[ptr];

    // Stack pointer and slot writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                stk[i] <= '0;
            end
        end else begin
            case ({push, pop})
                2'b10: begin
                    ptr         <= ptr_up;
                    stk[ptr_up] <= push_addr;
                end
                2'b01: ptr <= ptr_dn;
                2'b11: stk[ptr] <= push_addr;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gshare_bpu.sv
// Module: gshare branch prediction unit (top).
// The lookup is combinational: direction from the counter table, target
// and kind from the target buffer, return targets from the return stack.
// Updates, pushes, pops and history changes take effect at the next edge.
// Assumes word-aligned PCs and a history no wider than the PC bits above 2.
module gshare_bpu #(
    parameter int ADDR_W    = 64,
    parameter int HIST_W    = 12,
    parameter int BTB_DEPTH = 512,
    parameter int BTB_TAG_W = 20,
    parameter int RAS_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    output logic              lk_btb_hit,
    output logic [HIST_W-1:0] lk_ghr,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    input  logic [1:0]        up_kind,
    input  logic              up_mispredict,
    input  logic [HIST_W-1:0] up_ghr_snap,
    input  logic              ras_push,
    input  logic [ADDR_W-1:0] ras_push_addr,
    input  logic              ras_pop
);
    import bpu_pkg::*;

    localparam int BTB_IDX_W = $clog2(BTB_DEPTH);
    localparam int TAG_LO    = BTB_IDX_W + 2;
    localparam int TAG_HI    = TAG_LO + BTB_TAG_W - 1;
    localparam int PHT_HI    = HIST_W + 1;
    localparam int RAS_PTR_W = $clog2(RAS_DEPTH);

    br_kind_e              up_kind_e;
    br_kind_e              hit_kind;
    logic [ADDR_W-1:0]     btb_target;
    logic [ADDR_W-1:0]     ras_top;
    logic [RAS_PTR_W-1:0]  ras_ptr;
    logic [HIST_W-1:0]     ghr;
    logic [HIST_W-1:0]     pht_rd_idx;
    logic [HIST_W-1:0]     pht_wr_idx;
    logic                  pht_taken;
    logic                  up_is_cond;
    logic                  unused_up_bits;

    assign up_kind_e      = br_kind_e'(up_kind);
    assign up_is_cond     = (up_kind_e == BK_COND);
    assign unused_up_bits = ^{up_pc[1:0], up_pc[ADDR_W-1:TAG_HI+1]};

    // Hashed counter indices for the lookup and the training write
    always_comb begin
        pht_rd_idx = lk_pc[PHT_HI:2] ^ ghr;
        pht_wr_idx = up_pc[PHT_HI:2] ^ up_ghr_snap;
    end

    bpu_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .spec_en     (lk_valid && lk_btb_hit && (hit_kind == BK_COND)),
        .spec_bit    (pht_taken),
        .fix_en      (up_valid && up_mispredict),
        .fix_is_cond (up_is_cond),
        .fix_bit     (up_taken),
        .fix_snap    (up_ghr_snap),
        .hist        (ghr)
    );

    bpu_pht #(.IDX_W(HIST_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pht_rd_idx),
        .rd_taken (pht_taken),
        .wr_en    (up_valid && up_is_cond),
        .wr_idx   (pht_wr_idx),
        .wr_taken (up_taken)
    );

    bpu_btb #(
        .DEPTH  (BTB_DEPTH),
        .TAG_W  (BTB_TAG_W),
        .ADDR_W (ADDR_W)
    ) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_pc[TAG_LO-1:2]),
        .rd_tag    (lk_pc[TAG_HI:TAG_LO]),
        .rd_hit    (lk_btb_hit),
        .rd_target (btb_target),
        .rd_kind   (hit_kind),
        .wr_en     (up_valid && (up_taken || !up_is_cond)),
        .wr_idx    (up_pc[TAG_LO-1:2]),
        .wr_tag    (up_pc[TAG_HI:TAG_LO]),
        .wr_target (up_target),
        .wr_kind   (up_kind_e)
    );

    bpu_ras #(
        .DEPTH  (RAS_DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ras_push),
        .push_addr (ras_push_addr),
        .pop       (ras_pop),
        .top       (ras_top),
        .ptr       (ras_ptr)
    );

    assign lk_ghr = ghr;

    // Prediction: fall-through unless the buffer hits and the kind says go
    always_comb begin
        lk_taken  = 1'b0;
        lk_target = lk_pc + ADDR_W'(4);
        if (lk_btb_hit) begin
            case (hit_kind)
                BK_COND: begin
                    if (pht_taken) begin
                        lk_taken  = 1'b1;
                        lk_target = btb_target;
                    end
                end
                BK_RET: begin
                    lk_taken  = 1'b1;
                    lk_target = ras_top;
                end
                default: begin
                    lk_taken  = 1'b1;
                    lk_target = btb_target;
                end
            endcase
        end
    end

endmodule

// File: rtl/bpu_checker.sv
// Module: property checker for gshare_bpu, attached by bind.
// Observes ports plus the stack pointer and the kind of the hit entry.
module bpu_checker #(
    parameter int ADDR_W    = 64,
    parameter int HIST_W    = 12,
    parameter int RAS_DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         lk_valid,
    input logic [ADDR_W-1:0]            lk_pc,
    input logic                         lk_taken,
    input logic [ADDR_W-1:0]            lk_target,
    input logic                         lk_btb_hit,
    input logic [HIST_W-1:0]            lk_ghr,
    input logic                         up_valid,
    input logic                         up_taken,
    input logic [1:0]                   up_kind,
    input logic                         up_mispredict,
    input logic [HIST_W-1:0]            up_ghr_snap,
    input logic                         ras_push,
    input logic                         ras_pop,
    input logic [$clog2(RAS_DEPTH)-1:0] ras_ptr,
    input logic [1:0]                   hit_kind
);
    localparam int PW = $clog2(RAS_DEPTH);

    // R4: a buffer miss never redirects fetch
    p_miss_fallthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_btb_hit |-> (!lk_taken && lk_target == lk_pc + ADDR_W'(4)));

    // R6 and R7: non-conditional hits are always taken
    p_uncond_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_btb_hit && hit_kind != 2'd0) |-> lk_taken);

    // R9: a conditional hit shifts its guess into the history
    p_ghr_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_btb_hit && hit_kind == 2'd0 && !(up_valid && up_mispredict))
        |=> lk_ghr == {$past(lk_ghr[HIST_W-2:0]), $past(lk_taken)});

    // R9: no lookup and no update leaves the history alone
    p_ghr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid && !up_valid) |=> $stable(lk_ghr));

    // R10: conditional repair rebuilds history from snapshot and outcome
    p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_mispredict && up_kind == 2'd0)
        |=> lk_ghr == {$past(up_ghr_snap[HIST_W-2:0]), $past(up_taken)});

    // R8: a lone push advances the pointer with wrap
    p_push_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_push && !ras_pop)
        |=> ras_ptr == (($past(ras_ptr) == PW'(RAS_DEPTH - 1)) ? '0 : $past(ras_ptr) + 1'b1));

    // R8: push and pop together keep the pointer
    p_pushpop_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_push && ras_pop) |=> $stable(ras_ptr));

endmodule

bind gshare_bpu bpu_checker #(
    .ADDR_W    (ADDR_W),
    .HIST_W    (HIST_W),
    .RAS_DEPTH (RAS_DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_pc         (lk_pc),
    .lk_taken      (lk_taken),
    .lk_target     (lk_target),
    .lk_btb_hit    (lk_btb_hit),
    .lk_ghr        (lk_ghr),
    .up_valid      (up_valid),
    .up_taken      (up_taken),
    .up_kind       (up_kind),
    .up_mispredict (up_mispredict),
    .up_ghr_snap   (up_ghr_snap),
    .ras_push      (ras_push),
    .ras_pop       (ras_pop),
    .ras_ptr       (ras_ptr),
    .hit_kind      (hit_kind)
);

// File: tb/gshare_bpu_tb.sv
// Bench for gshare_bpu: directed corners then seeded random traffic,
// compared against a reference model kept from the requirements.
module gshare_bpu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_pc = '0;
    logic        lk_taken;
    logic [63:0] lk_target;
    logic        lk_btb_hit;
    logic [11:0] lk_ghr;
    logic        up_valid = 1'b0;
    logic [63:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [63:0] up_target = '0;
    logic [1:0]  up_kind = '0;
    logic        up_mispredict = 1'b0;
    logic [11:0] up_ghr_snap = '0;
    logic        ras_push = 1'b0;
    logic [63:0] ras_push_addr = '0;
    logic        ras_pop = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    logic [1:0]  m_pht [4096];
    bit          m_bv [512];
    logic [19:0] m_btag [512];
    logic [63:0] m_btgt [512];
    logic [1:0]  m_bkind [512];
    logic [63:0] m_ras [16];
    int          m_ptr;
    logic [11:0] m_ghr;

    always #4 clk = ~clk;

    gshare_bpu u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_taken(lk_taken), .lk_target(lk_target), .lk_btb_hit(lk_btb_hit),
        .lk_ghr(lk_ghr), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_target(up_target), .up_kind(up_kind), .up_mispredict(up_mispredict),
        .up_ghr_snap(up_ghr_snap), .ras_push(ras_push),
        .ras_push_addr(ras_push_addr), .ras_pop(ras_pop)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) m_pht[i] = 2'd1;
        for (int i = 0; i < 512; i++) m_bv[i] = 1'b0;
        for (int i = 0; i < 16; i++) m_ras[i] = '0;
        m_ptr = 0;
        m_ghr = '0;
    endtask

    function automatic bit exp_hit(input logic [63:0] pc);
        return m_bv[pc[10:2]] && (m_btag[pc[10:2]] == pc[30:11]);
    endfunction

    function automatic bit exp_taken(input logic [63:0] pc);
        if (!exp_hit(pc)) return 1'b0;
        if (m_bkind[pc[10:2]] != 2'd0) return 1'b1;
        return m_pht[pc[13:2] ^ m_ghr] >= 2'd2;
    endfunction

    function automatic logic [63:0] exp_target(input logic [63:0] pc);
        if (!exp_taken(pc)) return pc + 64'd4;
        if (m_bkind[pc[10:2]] == 2'd3) return m_ras[m_ptr];
        return m_btgt[pc[10:2]];
    endfunction

    // One cycle: drive, compare outputs, advance the model for the edge
    task automatic cyc(input string req, input bit lv, input logic [63:0] pc,
                       input bit uv, input logic [63:0] upc, input bit ut,
                       input logic [63:0] utgt, input logic [1:0] uk,
                       input bit um, input logic [11:0] usnap,
                       input bit push, input logic [63:0] paddr, input bit pop);
        bit h, t;
        int bi;
        @(negedge clk);
        lk_valid = lv; lk_pc = pc;
        up_valid = uv; up_pc = upc; up_taken = ut; up_target = utgt;
        up_kind = uk; up_mispredict = um; up_ghr_snap = usnap;
        ras_push = push; ras_push_addr = paddr; ras_pop = pop;
        #1;
        h = exp_hit(pc);
        t = exp_taken(pc);
        chk(req, "hit", {63'd0, lk_btb_hit}, {63'd0, h});
        chk(req, "taken", {63'd0, lk_taken}, {63'd0, t});
        chk(req, "target", lk_target, exp_target(pc));
        chk(req, "ghr", {52'd0, lk_ghr}, {52'd0, m_ghr});
        // history
        if (uv && um) m_ghr = (uk == 2'd0) ? {usnap[10:0], ut} : usnap;
        else if (lv && h && m_bkind[pc[10:2]] == 2'd0) m_ghr = {m_ghr[10:0], t};
        // counters
        if (uv && uk == 2'd0) begin
            bi = int'(upc[13:2] ^ usnap);
            if (ut) m_pht[bi] = (m_pht[bi] == 2'd3) ? 2'd3 : m_pht[bi] + 2'd1;
            else    m_pht[bi] = (m_pht[bi] == 2'd0) ? 2'd0 : m_pht[bi] - 2'd1;
        end
        // target buffer
        if (uv && (ut || uk != 2'd0)) begin
            bi = int'(upc[10:2]);
            m_bv[bi] = 1'b1; m_btag[bi] = upc[30:11];
            m_btgt[bi] = utgt; m_bkind[bi] = uk;
        end
        // return stack
        if (push && !pop) begin
            m_ptr = (m_ptr + 1) % 16; m_ras[m_ptr] = paddr;
        end else if (pop && !push) begin
            m_ptr = (m_ptr + 15) % 16;
        end else if (push && pop) begin
            m_ras[m_ptr] = paddr;
        end
    endtask

    // shorthands
    task automatic look(input string req, input bit lv, input logic [63:0] pc);
        cyc(req, lv, pc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic upd(input string req, input logic [63:0] upc, input bit ut,
                       input logic [63:0] utgt, input logic [1:0] uk,
                       input bit um, input logic [11:0] usnap);
        cyc(req, 0, upc, 1, upc, ut, utgt, uk, um, usnap, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] pa, pb, pc_al, pr, pj;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        pa = 64'h0000_0000_4000_0100;
        pb = 64'h0000_0000_4000_0200;
        pc_al = pb + 64'h800;           // same buffer index, other tag
        pr = 64'h0000_0000_4000_0300;
        pj = 64'h0000_0000_4000_0040;

        // R1: clean state after reset
        look("R1", 0, pa);
        look("R1", 1, 64'h1234_5678_9abc_def0);

        // R11: not-taken conditional does not allocate
        upd("R11", pa, 0, 64'hdead_0000, 2'd0, 0, 12'd0);
        look("R11", 0, pa);

        // R2/R3: step the counter up to 3, one more taken must stay 3
        for (int i = 0; i < 4; i++) upd("R3", pa, 1, 64'h5000, 2'd0, 0, 12'd0);
        look("R2", 0, pa);
        upd("R3", pa, 0, 64'h5000, 2'd0, 0, 12'd0);   // 3 -> 2 still taken
        look("R3", 0, pa);
        for (int i = 0; i < 4; i++) upd("R3", pa, 0, 64'h5000, 2'd0, 0, 12'd0);
        upd("R3", pa, 1, 64'h5000, 2'd0, 0, 12'd0);   // 0 -> 1 not taken
        look("R3", 0, pa);
        upd("R2", pa, 1, 64'h5000, 2'd0, 0, 12'd0);   // 1 -> 2 taken
        look("R2", 0, pa);

        // R9: valid conditional hit shifts the guess
        look("R9", 1, pa);
        look("R9", 1, pa);
        look("R2", 0, pa);     // index now hashed with non-zero history

        // R10: repair from a snapshot, conditional and jump, with lookup racing
        cyc("R10", 1, pa, 1, pj, 0, 64'h7000, 2'd0, 1, 12'hA5C, 0, 0, 0);
        look("R10", 0, pa);
        upd("R10", pj, 1, 64'h7000, 2'd1, 1, 12'h3C3);
        look("R6", 0, pj);     // R6: jump hit taken to stored target

        // R4/R5: strong counter, then alias evicts entry -> fall-through
        for (int i = 0; i < 3; i++) upd("R4", pb, 1, 64'h6000, 2'd0, 0, 12'h3C3);
        look("R4", 0, pb);
        upd("R5", pc_al, 1, 64'h6800, 2'd2, 0, 12'd0);
        look("R5", 0, pc_al);
        look("R4", 0, pb);

        // R7/R8: return entry, pop from empty, overflow wrap
        upd("R7", pr, 1, 64'h0, 2'd3, 0, 12'd0);
        look("R7", 0, pr);
        cyc("R8", 0, pr, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); // pop empty
        look("R8", 0, pr);
        for (int i = 1; i <= 17; i++)
            cyc("R8", 0, pr, 0, 0, 0, 0, 0, 0, 0, 1, 64'h9000 + 64'(i * 4), 0);
        look("R7", 0, pr);
        cyc("R8", 0, pr, 0, 0, 0, 0, 0, 0, 0, 1, 64'hAAA0, 1); // replace top
        for (int i = 0; i < 16; i++)
            cyc("R8", 0, pr, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // Random mix over a small aliasing address pool
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] rpc, upc;
            bit um;
            rpc = 64'h4000_0000 | (64'($urandom_range(0, 2)) << 11) | (64'($urandom_range(0, 7)) << 2);
            upc = 64'h4000_0000 | (64'($urandom_range(0, 2)) << 11) | (64'($urandom_range(0, 7)) << 2);
            um = ($urandom_range(0, 7) == 0);
            cyc("R2", $urandom_range(0, 1) == 1, rpc,
                $urandom_range(0, 1) == 1, upc, $urandom_range(0, 1) == 1,
                64'h8000_0000 + 64'($urandom_range(0, 255) * 4),
                2'($urandom_range(0, 3)), um, 12'($urandom_range(0, 4095)),
                $urandom_range(0, 5) == 0, 64'hC000 + 64'($urandom_range(0, 1023) * 4),
                $urandom_range(0, 5) == 0);
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule